// File: doc/BRIEF.md
# Minimal Adaptive Wormhole Mesh Router

This block is a single node of a two-dimensional mesh on-chip network. It has five flit ports: one towards a processing element and four towards the north, south, east and west neighbours. Every port carries a flit input and a flit output, each with valid/ready flow control. Packets use wormhole switching. A head flit names the destination tile. Once the head flit has won an output, the body and tail flits follow it through that output with no further routing decision.

Every input port has a small FIFO. The routing work is divided between two sub-routers. One deals with packets whose destination column is at or to the east of the node, including packets for the local tile. The other deals with packets whose destination column is to the west. Each sub-router only ever offers productive directions. When a packet can usefully go both horizontally and vertically, the sub-router chooses between the two each cycle from the live state of those outputs, not from a fixed dimension order. Each output resolves competing head flits by round-robin and then stays reserved for the winning packet until its tail leaves.

The node's coordinates are parameters. Column numbers grow towards the east and row numbers grow towards the south, so the north output leads to the row numbered one lower.

Top module: `mesh_router`

## Requirements
- R1: After reset every output valid is low and every input ready is high.
- R2: A head flit whose destination equals the node's own coordinates leaves only through the local port (index 0).
- R3: If only the destination column matches, the packet uses the north or south output. If only the destination row matches, it uses the east or west output. This holds even when that output's downstream ready is low.
- R4: A head flit never leaves through a non-productive output. Flit bits [33:32] give the type (00 idle, 01 head, 10 body, 11 tail). In the head payload, bits [3:0] hold the destination column and bits [7:4] hold the destination row. Port indices are local 0, north 1, south 2, east 3, west 4.
- R5: A packet may have both a horizontal and a vertical productive direction. The chosen output is then decided in this order:
  - If exactly one of the two is free (not reserved, and its downstream ready was high in the previous cycle), that one is taken.
  - Otherwise the one with the larger saturating idle count is taken.
  - On equal idle counts, the horizontal one is taken.
- R6: On each output, the flits of a packet leave contiguously and in order, with their content unchanged and with no flit of another packet between them. Each input's packets leave in the order they arrived.
- R7: A reservation ends on the cycle its tail flit is accepted downstream. A waiting competitor's head can then leave on the next cycle. Competing inputs for one output are served round-robin.
- R8: Each input FIFO holds 4 flits. Once 4 flits are waiting, ready to the upstream port goes low.
- R9: While an output is valid and its ready is low, the output stays valid and its flit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Flit valid per input port |
| in_flit_i | input | 5x34 | Flit per input port |
| in_ready_o | output | 5 | FIFO can accept a flit, per input port |
| out_valid_o | output | 5 | Flit valid per output port |
| out_flit_o | output | 5x34 | Flit per output port |
| out_ready_i | input | 5 | Downstream accepts a flit, per output port |

## Verification
Two things can coincide on one output. A tail flit can be accepted, ending a reservation, in the same cycle that another input's head is already waiting to claim that output. This is provoked by two inputs each streaming two packets to the same southbound output. The arrival order must alternate between the two sources, and each new head must appear exactly one cycle after the previous tail. The adaptive choice is also exercised at the same moment as an output release: a packet to a diagonal tile is queued directly behind one that has just used the east output, and it must turn south because the east idle count was just cleared. An all-pairs sweep with a rotating ready pattern checks every delivery against the productive directions of its destination.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NP = 5;
  localparam int PW = 32;
  localparam int FW = PW + 2;
  localparam int P_L = 0;
  localparam int P_N = 1;
  localparam int P_S = 2;
  localparam int P_E = 3;
  localparam int P_W = 4;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } ftype_e;

  function automatic ftype_e ftype(input logic [FW-1:0] f);
    return ftype_e'(f[FW-1:FW-2]);
  endfunction
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic wr, rd;

  assign ready_o = (cnt_q != FULL);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign wr = push_i && ready_o;
  assign rd = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      mem_q <= '0;
    end else begin
      if (wr) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (rd) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (wr && !rd) cnt_q <= cnt_q + 1'b1;
      else if (rd && !wr) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL && !rd) |=> (cnt_q == FULL));
endmodule

// File: rtl/rtr_half.sv
module rtr_half
  import rtr_pkg::*;
#(
  parameter int SIDE   = 0,  // 0: destination column >= own, 1: destination column < own
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int CW     = 4,
  parameter int IDLE_W = 4
) (
  input  logic [NP-1:0]             cand_i,
  input  logic [NP-1:0][FW-1:0]     flit_i,
  input  logic [NP-1:0]             free_i,
  input  logic [NP-1:0][IDLE_W-1:0] idle_i,
  output logic [NP-1:0][NP-1:0]     req_o
);
  localparam logic [CW-1:0] X0 = CW'(MY_X);
  localparam logic [CW-1:0] Y0 = CW'(MY_Y);
  localparam int HDIR = (SIDE == 0) ? P_E : P_W;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [CW-1:0] dx, dy;
    logic mine, h_ok, v_ok;
    int vdir, pick;

    always_comb begin
      dx   = flit_i[i][CW-1:0];
      dy   = flit_i[i][2*CW-1:CW];
      mine = (SIDE == 0) ? (dx >= X0) : (dx < X0);
      h_ok = (dx != X0);
      v_ok = (dy != Y0);
      vdir = (dy < Y0) ? P_N : P_S;
      if (!h_ok && !v_ok) pick = P_L;
      else if (!h_ok) pick = vdir;
      else if (!v_ok) pick = HDIR;
      else if (free_i[HDIR] && !free_i[vdir]) pick = HDIR;
      else if (free_i[vdir] && !free_i[HDIR]) pick = vdir;
      else if (idle_i[vdir] > idle_i[HDIR]) pick = vdir;
      else pick = HDIR;
      req_o[i] = '0;
      if (cand_i[i] && mine) req_o[i][pick] = 1'b1;
    end
  end
endmodule

// File: rtl/rtr_arb.sv
module rtr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         tail_xfer_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] lock_o
);
  localparam int IW = $clog2(N);

  logic         res_q, found;
  logic [IW-1:0] own_q, rr_q, pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
    lock_o = '0;
    if (res_q) lock_o[own_q] = 1'b1;
    sel_o = lock_o;
    if (!res_q && found) sel_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= 1'b0;
      own_q <= '0;
      rr_q  <= '0;
    end else if (res_q) begin
      if (tail_xfer_i) res_q <= 1'b0;
    end else if (found) begin
      res_q <= 1'b1;
      own_q <= pick;
      rr_q  <= pick;
    end
  end

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q && tail_xfer_i) |=> !res_q);
  assert_grant_has_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_q && (sel_o != '0)) |-> ((sel_o & req_i) != '0));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import rtr_pkg::*;
#(
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int CW     = 4,
  parameter int DEPTH  = 4,
  parameter int IDLE_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [4:0]            in_valid_i,
  input  logic [4:0][33:0]      in_flit_i,
  output logic [4:0]            in_ready_o,
  output logic [4:0]            out_valid_o,
  output logic [4:0][33:0]      out_flit_o,
  input  logic [4:0]            out_ready_i
);
  localparam logic [CW-1:0] X0 = CW'(MY_X);
  localparam logic [CW-1:0] Y0 = CW'(MY_Y);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [NP-1:0] f_valid, f_pop, hold, cand, free, ready_q, xfer, tail_x;
  logic [NP-1:0][FW-1:0] f_data;
  logic [1:0][NP-1:0][NP-1:0] req_h;
  logic [NP-1:0][NP-1:0] req_io, req_oi, sel, lock;
  logic [NP-1:0][IDLE_W-1:0] idle_q;

  for (genvar i = 0; i < NP; i++) begin : g_fifo
    rtr_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i (in_valid_i[i]),
      .data_i (in_flit_i[i]),
      .ready_o(in_ready_o[i]),
      .pop_i  (f_pop[i]),
      .valid_o(f_valid[i]),
      .data_o (f_data[i])
    );
  end

  // An input that already holds an output must not route its front again.
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      hold[i] = 1'b0;
      for (int o = 0; o < NP; o++) hold[i] = hold[i] | lock[o][i];
      cand[i] = f_valid[i] && (ftype(f_data[i]) == FT_HEAD) && !hold[i];
    end
    for (int o = 0; o < NP; o++) free[o] = ready_q[o] && (lock[o] == '0);
  end

  for (genvar s = 0; s < 2; s++) begin : g_half
    rtr_half #(.SIDE(s), .MY_X(MY_X), .MY_Y(MY_Y), .CW(CW), .IDLE_W(IDLE_W)) u_half (
      .cand_i(cand), .flit_i(f_data), .free_i(free), .idle_i(idle_q), .req_o(req_h[s])
    );
  end

  always_comb begin
    req_io = req_h[0] | req_h[1];
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++) req_oi[o][i] = req_io[i][o];
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    rtr_arb #(.N(NP)) u_arb (
      .clk_i, .rst_ni,
      .req_i      (req_oi[o]),
      .tail_xfer_i(tail_x[o]),
      .sel_o      (sel[o]),
      .lock_o     (lock[o])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      out_valid_o[o] = 1'b0;
      out_flit_o[o]  = '0;
      for (int i = 0; i < NP; i++)
        if (sel[o][i]) begin
          out_valid_o[o] = f_valid[i];
          out_flit_o[o]  = f_data[i];
        end
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      xfer[o]   = out_valid_o[o] && out_ready_i[o];
      tail_x[o] = xfer[o] && (ftype(out_flit_o[o]) == FT_TAIL);
    end
    for (int i = 0; i < NP; i++) begin
      f_pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) f_pop[i] = f_pop[i] | (sel[o][i] & out_ready_i[o] & f_valid[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= '0;
      idle_q  <= '0;
    end else begin
      ready_q <= out_ready_i;
      for (int o = 0; o < NP; o++)
        if (xfer[o]) idle_q[o] <= '0;
        else if (idle_q[o] != IDLE_MAX) idle_q[o] <= idle_q[o] + 1'b1;
    end
  end

  function automatic logic productive(input int o, input logic [FW-1:0] f);
    logic [CW-1:0] dx, dy;
    dx = f[CW-1:0];
    dy = f[2*CW-1:CW];
    case (o)
      P_L:     return (dx == X0) && (dy == Y0);
      P_N:     return dy < Y0;
      P_S:     return dy > Y0;
      P_E:     return dx > X0;
      default: return dx < X0;
    endcase
  endfunction

  for (genvar o = 0; o < NP; o++) begin : g_chk
    assert_min_route_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && ftype(out_flit_o[o]) == FT_HEAD) |-> productive(o, out_flit_o[o]));
    assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |=> (out_valid_o[o] && $stable(out_flit_o[o])));
    assert_head_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && lock[o] == '0) |-> (ftype(out_flit_o[o]) == FT_HEAD));
  end
  assert_local_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o[P_L] && ftype(out_flit_o[P_L]) == FT_HEAD) |->
      (out_flit_o[P_L][CW-1:0] == X0 && out_flit_o[P_L][2*CW-1:CW] == Y0));
endmodule

// File: tb/mesh_router_bench.sv
module mesh_router_bench;
  import rtr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MX = 1;
  localparam int MY = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [4:0][33:0] in_flit = '0, out_flit;

  mesh_router #(.MY_X(MX), .MY_Y(MY)) u_mesh_router (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_flit_i(in_flit),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_flit_o(out_flit), .out_ready_i(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int src_of[256], out_of[256];
  bit sent[256], got[256];
  int last_done[5], cur_id[5], nseq[5], tail_cyc[5];
  bit auto_rdy = 1'b0, rec_s = 1'b0, cnt_acc = 1'b0;
  int s_src[8], s_gap[8], s_n = 0, acc_n = 0;
  logic [4:0] stall_q = '0;
  logic [4:0][33:0] stall_f;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [33:0] mk(input logic [1:0] t, input int id, input int seq, input int dx, input int dy);
    return {t, 16'(id), 8'(seq), 4'(dy), 4'(dx)};
  endfunction

  task automatic send(input int p, input int id, input int dx, input int dy, input int nbody);
    src_of[id] = p;
    sent[id] = 1'b1;
    for (int k = 0; k <= nbody + 1; k++) begin
      in_valid[p] = 1'b1;
      in_flit[p] = mk(k == 0 ? 2'b01 : (k == nbody + 1 ? 2'b11 : 2'b10), id, k, dx, dy);
      forever begin
        @(negedge clk);
        if (in_ready[p]) break;
      end
      @(posedge clk);
      #1;
    end
    in_valid[p] = 1'b0;
  endtask

  function automatic bit legal(input int p, input int dx, input int dy);
    case (p)
      P_N:     return dy >= MY;
      P_S:     return dy <= MY;
      P_E:     return dx <= MX;
      P_W:     return dx >= MX;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_port(input int p);
    for (int dx = 0; dx < 3; dx++)
      for (int dy = 0; dy < 3; dy++)
        if (legal(p, dx, dy)) send(p, p * 10 + dx * 3 + dy, dx, dy, (dx + dy + p) % 3);
  endtask

  always @(posedge clk) begin
    #1;
    if (auto_rdy)
      for (int o = 0; o < 5; o++) out_ready[o] = ((cyc + o * 3) % 5) != 0;
  end

  // Output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_acc && in_valid[P_L] && in_ready[P_L]) acc_n++;
      for (int o = 0; o < 5; o++) begin
        if (stall_q[o])
          chk(out_valid[o] && out_flit[o] == stall_f[o], "R9", "flit held under back-pressure", int'(out_valid[o]), 1);
        stall_q[o] = out_valid[o] && !out_ready[o];
        stall_f[o] = out_flit[o];
        if (out_valid[o] && out_ready[o]) begin
          logic [1:0] t;
          int id, seq, dx, dy;
          t = out_flit[o][33:32];
          id = int'(out_flit[o][31:16]);
          seq = int'(out_flit[o][15:8]);
          dy = int'(out_flit[o][7:4]);
          dx = int'(out_flit[o][3:0]);
          if (t == 2'b01) begin
            bit prod;
            chk(cur_id[o] < 0, "R6", "output idle when head leaves", cur_id[o], -1);
            case (o)
              P_L: prod = (dx == MX && dy == MY);
              P_N: prod = dy < MY;
              P_S: prod = dy > MY;
              P_E: prod = dx > MX;
              default: prod = dx < MX;
            endcase
            chk(prod, "R4", "head on productive output", o, -1);
            if (dx == MX && dy == MY) chk(o == P_L, "R2", "self packet to local", o, P_L);
            if (dx == MX && dy != MY) chk(o == P_N || o == P_S, "R3", "column match uses vertical", o, dy < MY ? P_N : P_S);
            if (dy == MY && dx != MX) chk(o == P_E || o == P_W, "R3", "row match uses horizontal", o, dx > MX ? P_E : P_W);
            chk(seq == 0, "R6", "head sequence", seq, 0);
            cur_id[o] = id;
            nseq[o] = 1;
            out_of[id] = o;
            if (rec_s && o == P_S && s_n < 8) begin
              s_src[s_n] = src_of[id];
              s_gap[s_n] = cyc - tail_cyc[o];
              s_n++;
            end
          end else begin
            chk(cur_id[o] == id, "R6", "flit belongs to open packet", id, cur_id[o]);
            chk(seq == nseq[o], "R6", "flit order", seq, nseq[o]);
            nseq[o]++;
            if (t == 2'b11) begin
              got[id] = 1'b1;
              chk(id > last_done[src_of[id]], "R6", "per-input packet order", id, last_done[src_of[id]] + 1);
              last_done[src_of[id]] = id;
              cur_id[o] = -1;
              tail_cyc[o] = cyc;
            end
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      cur_id[i] = -1;
      last_done[i] = -1;
      tail_cyc[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 5'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 5'b11111, "R1", "in_ready after reset", int'(in_ready), 31);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // All-pairs sweep with rotating back-pressure
    auto_rdy = 1'b1;
    fork
      run_port(0);
      run_port(1);
      run_port(2);
      run_port(3);
      run_port(4);
    join
    repeat (40) @(posedge clk);
    auto_rdy = 1'b0;
    #2;
    out_ready = '1;
    for (int id = 0; id < 50; id++)
      if (sent[id]) chk(got[id], "R6", "sweep packet delivered", int'(got[id]), 1);

    // R5 tie: everything idle and ready, horizontal wins
    repeat (20) @(posedge clk);
    #1;
    send(P_L, 100, 2, 2, 1);
    send(P_L, 101, 2, 2, 1);
    repeat (20) @(posedge clk);
    #1;
    chk(out_of[100] == P_E, "R5", "tie picks horizontal", out_of[100], P_E);
    chk(out_of[101] == P_S, "R5", "longer idle output preferred", out_of[101], P_S);

    // R5 busy: east not ready, south taken
    out_ready[P_E] = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    send(P_L, 102, 2, 2, 1);
    repeat (10) @(posedge clk);
    #1;
    chk(out_of[102] == P_S, "R5", "free output preferred", out_of[102], P_S);

    // R3: only east is productive; it waits for east
    fork
      send(P_L, 103, 2, 1, 1);
    join_none
    repeat (8) @(posedge clk);
    #1;
    chk(out_valid[P_E] && !out_valid[P_S] && !out_valid[P_N], "R3", "single direction waits", int'(out_valid), 8);
    out_ready[P_E] = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(out_of[103] == P_E && got[103], "R3", "row-match packet exits east", out_of[103], P_E);

    // R7: two inputs compete for south
    rec_s = 1'b1;
    fork
      begin
        send(P_L, 110, 1, 2, 1);
        send(P_L, 112, 1, 2, 1);
      end
      begin
        send(P_N, 111, 1, 2, 1);
        send(P_N, 113, 1, 2, 1);
      end
    join
    repeat (20) @(posedge clk);
    #1;
    rec_s = 1'b0;
    chk(s_n == 4, "R7", "packets on south", s_n, 4);
    for (int k = 1; k < 4; k++) begin
      chk(s_src[k] != s_src[k-1], "R7", "round-robin alternation", s_src[k], s_src[k-1] == P_L ? P_N : P_L);
      chk(s_gap[k] == 1, "R7", "head one cycle after tail", s_gap[k], 1);
    end

    // R8/R9: FIFO fills while every output is blocked
    out_ready = '0;
    cnt_acc = 1'b1;
    fork
      send(P_L, 120, 1, 0, 4);
    join_none
    repeat (12) @(posedge clk);
    #1;
    chk(!in_ready[P_L], "R8", "ready low when full", int'(in_ready[P_L]), 0);
    chk(acc_n == 4, "R8", "flits accepted before full", acc_n, 4);
    chk(out_valid[P_N] && out_flit[P_N][33:32] == 2'b01, "R9", "head waiting on north", int'(out_valid[P_N]), 1);
    cnt_acc = 1'b0;
    out_ready = '1;
    repeat (20) @(posedge clk);
    #1;
    chk(got[120] && out_of[120] == P_N, "R9", "blocked packet delivered north", out_of[120], P_N);

    finish_run();
  end
endmodule